// File: doc/BRIEF.md
# Receive Byte Ordering Unit

This unit sits behind a byte deserializer that delivers a two-byte receive word every clock. The deserializer can hand over the stream with its bytes split across words in the wrong place. The unit searches the incoming words for a fixed ordering byte. The ordering byte belongs in the low lane. When it turns up in the high lane instead, the unit shifts the stream by one lane. At that point it inserts a single pad byte and afterwards carries a held byte over from the previous word.

A search is armed by a rising edge on one of two trigger inputs. A select input chooses which one. In sync mode the trigger is the word-aligner sync status. In user mode it is a dedicated enable line. Each trigger drops the alignment flag and starts a fresh search. The flag rises when the ordering byte is found, whether or not a pad byte was needed. The chosen lane offset is then held until the next trigger. Data always moves through with one register stage, also while a search is running.

Top module: `rx_byte_order`

## Requirements
- R1: A synchronous active-high reset drives `aligned` low and `dout` to zero, sets the lane offset to zero (pass-through) and cancels any pending search, so an ordering byte arriving later without a trigger leaves `aligned` low.
- R2: While the lane offset is zero, `dout` equals the `din` of the previous cycle. Lane 0 is bits [7:0] and carries the earlier byte; lane 1 is bits [15:8].
- R3: With `trig_sel` = 0 (sync mode), a rising edge on `sync_stat` starts a search and `aligned` is low in the following cycle.
- R4: With `trig_sel` = 1 (user mode), a rising edge on `user_en` starts the search, and edges on `sync_stat` have no effect; with `trig_sel` = 0, edges on `user_en` have no effect.
- R5: During a search, a word with the ordering byte (default 8'hBC) in lane 0 ends the search: `aligned` is high one cycle later, and the data stays in pass-through with no pad.
- R6: During a search in pass-through, a word with the ordering byte only in lane 1 ends the search. The next `dout` is {din[7:0], PAD}, with the pad byte (default 8'hF7) in lane 0. Every later `dout` is {din[7:0], previous din[15:8]}, and `aligned` is high.
- R7: Once `aligned` is high, it and the lane offset are held until the next trigger edge. Trigger inputs held high, and ordering bytes in later words, change neither.
- R8: In sync mode, a further rising edge on `sync_stat` drops `aligned` in the next cycle and restarts the search.
- R9: If both lanes of a searched word hold the ordering byte, lane 0 wins and the offset becomes zero.
- R10: While the offset is one, a search that finds the ordering byte in lane 0 returns the unit to pass-through, so the next `dout` equals that `din`.
- R11: A trigger edge in the same cycle as a word holding the ordering byte re-arms the search and ignores that word; `aligned` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_sel | input | 1 | Trigger source: 0 selects sync status, 1 selects user enable |
| sync_stat | input | 1 | Word-aligner sync status level |
| user_en | input | 1 | User enable that requests a search |
| din | input | 16 | Deserialized word, lane 0 in bits [7:0] |
| dout | output | 16 | Reordered word, one cycle behind `din` |
| aligned | output | 1 | High once the ordering byte has been found |

## Verification
The lane offset appears at `dout` on the very next cycle. A wrong offset shows up at once as a byte pair in the wrong place or as a stray pad byte. A wrong search flag can stay hidden until the next word that carries the ordering byte. It then shows as `aligned` rising when it should not, or failing to rise, one cycle after that word. The stimulus therefore puts ordering bytes both inside and outside searches, in either lane and in both lanes. A cycle-accurate model in the bench compares `dout` and `aligned` on every cycle.

// File: rtl/rxbo_pkg.sv
package rxbo_pkg;

    typedef enum logic {
        TRIG_SYNC = 1'b0,
        TRIG_USER = 1'b1
    } trig_src_e;

    typedef struct packed {
        logic searching;
        logic aligned;
        logic offset;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{searching: 1'b0, aligned: 1'b0, offset: 1'b0};

endpackage

// File: rtl/rxbo_edge_detect.sv
module rxbo_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic rise_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = level_i;
        rise_o = level_i && !prev_q;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= prev_d;
    end

endmodule

// File: rtl/rxbo_lane_match.sv
module rxbo_lane_match #(
    parameter int          LANE_W  = 8,
    parameter int          LANES   = 2,
    parameter logic [7:0]  PATTERN = 8'hBC
) (
    input  logic [LANES*LANE_W-1:0] word_i,
    output logic [LANES-1:0]        hit_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign hit_o[g] = (word_i[g*LANE_W +: LANE_W] == PATTERN[LANE_W-1:0]);
    end
endmodule

// File: rtl/rxbo_lane_shift.sv
module rxbo_lane_shift #(
    parameter int         LANE_W = 8,
    parameter logic [7:0] PAD    = 8'hF7
) (
    input  logic [2*LANE_W-1:0] din_i,
    input  logic [LANE_W-1:0]   hold_i,
    input  logic                off_now_i,
    input  logic                off_next_i,
    output logic [2*LANE_W-1:0] word_o
);
    logic [LANE_W-1:0] low_src;

    always_comb begin
        low_src = off_now_i ? hold_i : PAD[LANE_W-1:0];
        if (off_next_i) word_o = {din_i[LANE_W-1:0], low_src};
        else            word_o = din_i;
    end
endmodule

// File: rtl/rx_byte_order.sv
module rx_byte_order #(
    parameter int         LANE_W  = 8,
    parameter logic [7:0] PATTERN = 8'hBC,
    parameter logic [7:0] PAD     = 8'hF7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                trig_sel,
    input  logic                sync_stat,
    input  logic                user_en,
    input  logic [2*LANE_W-1:0] din,
    output logic [2*LANE_W-1:0] dout,
    output logic                aligned
);
    import rxbo_pkg::*;

    localparam int LANES  = 2;
    localparam int WORD_W = LANES * LANE_W;

    logic              sync_rise, user_rise, trig;
    logic [LANES-1:0]  hit;
    logic              found;
    ctrl_t             ctrl_d, ctrl_q;
    logic [LANE_W-1:0] hold_d, hold_q;
    logic [WORD_W-1:0] dout_d, dout_q;

    rxbo_edge_detect u_sync_edge (
        .clk(clk), .rst(rst), .level_i(sync_stat), .rise_o(sync_rise)
    );

    rxbo_edge_detect u_user_edge (
        .clk(clk), .rst(rst), .level_i(user_en), .rise_o(user_rise)
    );

    rxbo_lane_match #(.LANE_W(LANE_W), .LANES(LANES), .PATTERN(PATTERN)) u_match (
        .word_i(din), .hit_o(hit)
    );

    always_comb begin
        trig   = (trig_src_e'(trig_sel) == TRIG_USER) ? user_rise : sync_rise;
        found  = ctrl_q.searching && !trig && (|hit);
        ctrl_d = ctrl_q;
        if (trig) begin
            ctrl_d.searching = 1'b1;
            ctrl_d.aligned   = 1'b0;
        end else if (found) begin
            ctrl_d.searching = 1'b0;
            ctrl_d.aligned   = 1'b1;
            ctrl_d.offset    = !hit[0];
        end
        hold_d = din[WORD_W-1:LANE_W];
    end

    rxbo_lane_shift #(.LANE_W(LANE_W), .PAD(PAD)) u_shift (
        .din_i(din), .hold_i(hold_q), .off_now_i(ctrl_q.offset),
        .off_next_i(ctrl_d.offset), .word_o(dout_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
            hold_q <= '0;
            dout_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            hold_q <= hold_d;
            dout_q <= dout_d;
        end
    end

    assign dout    = dout_q;
    assign aligned = ctrl_q.aligned;

    AST_RESET_STATE: assert property (@(posedge clk) rst |=> (!aligned && dout == '0)); // R1
    AST_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
        !ctrl_d.offset |=> dout == $past(din)); // R2
    AST_TRIG_CLEARS: assert property (@(posedge clk) disable iff (rst)
        trig |=> !aligned); // R3
    AST_ALIGN_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(ctrl_q.aligned && ctrl_q.searching)); // R5
    AST_PAD_ON_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.offset && ctrl_d.offset) |=> dout[LANE_W-1:0] == PAD[LANE_W-1:0]); // R6
    AST_ALIGN_STICKY: assert property (@(posedge clk) disable iff (rst)
        (aligned && !trig) |=> aligned); // R7
    AST_LOW_LANE_WINS: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.searching && !trig && hit[0]) |=> !ctrl_q.offset); // R9

endmodule

// File: tb/rx_byte_order_tb.sv
module rx_byte_order_tb;
    localparam int         CLK_PERIOD = 10;
    localparam logic [7:0] PAT = 8'hBC;
    localparam logic [7:0] PADB = 8'hF7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig_sel = 1'b0, sync_stat = 1'b0, user_en = 1'b0;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic        aligned;

    int checks = 0, errors = 0;

    // reference model state
    logic        m_ps, m_pu, m_srch, m_al, m_off;
    logic [7:0]  m_hold;
    logic [15:0] e_dout;
    logic        e_al;
    logic        have_exp = 1'b0;
    string       prev_tag = "";

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_byte_order u_dut (
        .clk(clk), .rst(rst), .trig_sel(trig_sel), .sync_stat(sync_stat),
        .user_en(user_en), .din(din), .dout(dout), .aligned(aligned)
    );

    task automatic model(input logic r, input logic md, input logic s,
                         input logic u, input logic [15:0] d);
        logic trg, mlo, mhi, hit, noff;
        if (r) begin
            m_ps = 0; m_pu = 0; m_srch = 0; m_al = 0; m_off = 0; m_hold = '0;
            e_dout = '0; e_al = 0;
        end else begin
            trg  = md ? (u && !m_pu) : (s && !m_ps);
            mlo  = (d[7:0] == PAT);
            mhi  = (d[15:8] == PAT);
            hit  = m_srch && !trg && (mlo || mhi);
            noff = hit ? !mlo : m_off;
            if (!noff)      e_dout = d;
            else if (m_off) e_dout = {d[7:0], m_hold};
            else            e_dout = {d[7:0], PADB};
            m_hold = d[15:8];
            if (trg)      begin m_srch = 1; m_al = 0; end
            else if (hit) begin m_srch = 0; m_al = 1; end
            m_off = noff;
            m_ps = s; m_pu = u;
            e_al = m_al;
        end
    endtask

    task automatic check_out();
        if (!have_exp) return;
        checks++;
        if (dout !== e_dout) begin
            errors++;
            $display("FAIL %s dout actual %h expected %h", prev_tag, dout, e_dout);
        end
        checks++;
        if (aligned !== e_al) begin
            errors++;
            $display("FAIL %s aligned actual %0b expected %0b", prev_tag, aligned, e_al);
        end
    endtask

    task automatic step(input string tag, input logic r, input logic md,
                        input logic s, input logic u, input logic [15:0] d);
        @(negedge clk);
        check_out();
        rst = r; trig_sel = md; sync_stat = s; user_en = u; din = d;
        model(r, md, s, u, d);
        have_exp = 1'b1;
        prev_tag = tag;
    endtask

    function automatic logic [15:0] rnd_word();
        logic [15:0] w;
        w = 16'($urandom);
        if (w[7:0]  == PAT) w[7:0]  = 8'h11;
        if (w[15:8] == PAT) w[15:8] = 8'h22;
        return w;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed_init;
        logic md, s, u;
        logic [15:0] w;
        seed_init = $urandom(32'd4242);
        // R1: reset state
        repeat (3) step("R1", 1, 0, 0, 0, rnd_word());
        // R1/R2: pass-through, no search pending so pattern ignored
        for (int i = 0; i < 6; i++) step("R2", 0, 0, 0, 0, rnd_word());
        step("R1", 0, 0, 0, 0, {8'h33, PAT});
        step("R1", 0, 0, 0, 0, {PAT, 8'h44});
        step("R1", 0, 0, 0, 0, rnd_word());
        // R3/R5: sync rise then lane-0 match
        step("R3", 0, 0, 1, 0, rnd_word());
        step("R3", 0, 0, 1, 0, rnd_word());
        step("R5", 0, 0, 1, 0, {8'h55, PAT});
        step("R5", 0, 0, 1, 0, rnd_word());
        // R7: held level and later patterns ignored
        step("R7", 0, 0, 1, 0, {PAT, 8'h66});
        step("R7", 0, 0, 1, 1, {PAT, 8'h67});
        step("R7", 0, 0, 1, 0, rnd_word());
        // R8/R6: new sync rise, lane-1 match inserts pad
        step("R8", 0, 0, 0, 0, rnd_word());
        step("R8", 0, 0, 1, 0, rnd_word());
        step("R8", 0, 0, 1, 0, rnd_word());
        step("R6", 0, 0, 1, 0, {PAT, 8'h77});
        for (int i = 0; i < 4; i++) step("R6", 0, 0, 1, 0, rnd_word());
        // R10: from offset one back to pass-through
        step("R10", 0, 0, 0, 0, rnd_word());
        step("R10", 0, 0, 1, 0, rnd_word());
        step("R10", 0, 0, 1, 0, {8'h12, PAT});
        for (int i = 0; i < 3; i++) step("R10", 0, 0, 1, 0, rnd_word());
        // R9: both lanes match after moving to offset one
        step("R9", 0, 0, 0, 0, rnd_word());
        step("R9", 0, 0, 1, 0, {PAT, 8'h01});
        step("R9", 0, 0, 1, 0, {PAT, 8'h02});
        step("R9", 0, 0, 0, 0, rnd_word());
        step("R9", 0, 0, 1, 0, rnd_word());
        step("R9", 0, 0, 1, 0, {PAT, PAT});
        step("R9", 0, 0, 1, 0, rnd_word());
        // R11: trigger and pattern in same cycle
        step("R11", 0, 0, 0, 0, rnd_word());
        step("R11", 0, 0, 1, 0, {PAT, 8'h03});
        step("R11", 0, 0, 1, 0, rnd_word());
        step("R11", 0, 0, 1, 0, rnd_word());
        // R4: user mode, sync edges ignored
        step("R4", 0, 1, 0, 0, rnd_word());
        step("R4", 0, 1, 1, 0, rnd_word());
        step("R4", 0, 1, 1, 1, rnd_word());
        step("R4", 0, 1, 0, 1, {PAT, 8'h04});
        step("R4", 0, 1, 1, 1, rnd_word());
        step("R4", 0, 1, 0, 1, rnd_word());
        // R4: sync mode, user edges ignored
        step("R4", 0, 0, 0, 0, rnd_word());
        step("R4", 0, 0, 0, 1, {8'h05, PAT});
        step("R4", 0, 0, 0, 1, rnd_word());
        // R1: reset mid-search cancels it
        step("R1", 0, 0, 1, 0, rnd_word());
        step("R1", 1, 0, 1, 0, rnd_word());
        step("R1", 0, 0, 1, 0, {PAT, 8'h06});
        step("R1", 0, 0, 1, 0, rnd_word());
        // random phase covering R2, R6, R7, R8
        md = 0; s = 0; u = 0;
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 199) == 0) md = !md;
            if ($urandom_range(0, 9) == 0) s = !s;
            if ($urandom_range(0, 9) == 0) u = !u;
            w = rnd_word();
            case ($urandom_range(0, 15))
                0: w[7:0]  = PAT;
                1: w[15:8] = PAT;
                2: w = {PAT, PAT};
                default: ;
            endcase
            step("R7", 0, md, s, u, w);
        end
        step("R2", 0, 0, 0, 0, rnd_word());
        @(negedge clk);
        check_out();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule